// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel data buses, side A and side B, and moves data between them in either direction. Each direction has a storage register with its own capture clock. The A-side register samples the A bus and the B-side register samples the B bus. For each direction a source select decides whether the opposite bus receives the live value of the source bus or the value held in that direction's register. A per-direction enable decides whether the block drives the opposite bus at all.

The A-to-B enable is active high and the B-to-A enable is active low. With both de-asserted, the two sides are isolated, and the registers still capture on every edge of their clocks. Pads are modelled as separate input, output-data and output-drive vectors on each side, so a thin wrapper can add tri-state cells. The live paths are combinational. When both directions are enabled in live mode, the two buses form a loop that holds its last value after outside drivers let go. When both directions are enabled in stored mode, the two registers are exchanged across the buses.

Top module: `dual_reg_xcvr`

## Requirements
- R1: On each rising edge of `clk_ab` with `rst_n` high, the A register loads `a_in`. While `sel_ab` is 1, `b_out` equals that register.
- R2: On each rising edge of `clk_ba` with `rst_n` high, the B register loads `b_in`. While `sel_ba` is 1, `a_out` equals that register.
- R3: Register capture does not depend on `oe_ab`, `oe_ba_n`, `sel_ab` or `sel_ba`. Data captured while both sides are isolated can be read out later.
- R4: `b_drive` is all ones when `oe_ab` is 1 and all zeros when `oe_ab` is 0.
- R5: `a_drive` is all ones when `oe_ba_n` is 0 and all zeros when `oe_ba_n` is 1.
- R6: While `sel_ab` is 0, `b_out` equals `a_in` in the same cycle, with no clock edge needed.
- R7: While `sel_ba` is 0, `a_out` equals `b_in` in the same cycle.
- R8: A rising edge of a capture clock while `rst_n` is 0 clears that direction's register to zero. The other register is unaffected.
- R9: With `oe_ab`=1, `oe_ba_n`=0 and both selects 0, both buses keep their last value after every outside driver releases them.
- R10: With both enables asserted and both selects 1, the A register drives the B bus and the B register drives the A bus together. A simultaneous edge on both clocks exchanges the two values.
- R11: An edge on one capture clock leaves the other direction's register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A register |
| clk_ba | input | 1 | Capture clock of the B register |
| rst_n | input | 1 | Synchronous active-low clear, applied at the edge of each capture clock |
| oe_ab | input | 1 | Drive enable for the B bus, active high |
| oe_ba_n | input | 1 | Drive enable for the A bus, active low |
| sel_ab | input | 1 | B bus source: 0 live A bus, 1 A register |
| sel_ba | input | 1 | A bus source: 0 live B bus, 1 B register |
| a_in | input | W | Value present on the A bus |
| a_out | output | W | Data the block presents to the A bus |
| a_drive | output | W | Per-bit drive enable for the A bus |
| b_in | input | W | Value present on the B bus |
| b_out | output | W | Data the block presents to the B bus |
| b_drive | output | W | Per-bit drive enable for the B bus |

## Verification
A register capture and an output transfer can happen in the same cycle. The hardest case is an edge on both clocks while both directions drive stored data, because each register then samples a bus that the other register is driving. The bench provokes this with both enables asserted and both selects high, pulses both clocks on the same edge, and expects the two bus values to swap after that edge. A bus model drives both sides of the block, holds a bus when nobody drives it, and counts every cycle in which an outside source and the block drive the same bus.

// File: rtl/xcvr_pkg.sv
// Package: shared types for the registered transceiver.
// Assumes: one source select per direction, one bit wide.
package xcvr_pkg;

    // Source of the data driven onto the opposite bus
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_e;

endpackage

// File: rtl/xcvr_store.sv
// Module: xcvr_store
// One direction's storage register. It samples the source bus on every rising
// edge of its own clock, whatever the enables and selects are.
// Assumes: rst_n is synchronous to clk and active low.
module xcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture the source bus, or clear it under reset
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/xcvr_path.sv
// Module: xcvr_path
// One transfer direction. It picks live or stored data and turns the enable
// into a per-bit drive vector. The enable polarity is chosen by a parameter.
// Assumes: purely combinational, with no state of its own.
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int W             = 8,
    parameter bit OE_ACTIVE_LOW = 1'b0
) (
    input  logic         oe,
    input  src_e         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] dout,
    output logic [W-1:0] drive
);

    logic en;

    // Normalise the enable polarity
    generate
        if (OE_ACTIVE_LOW) begin : g_low
            assign en = ~oe;
        end else begin : g_high
            assign en = oe;
        end
    endgenerate

    // Choose the data for the opposite bus
    always_comb begin
        unique case (sel)
            SRC_STORED: dout = stored;
            default:    dout = live;
        endcase
    end

    // Spread the enable across every bit of the pad
    always_comb begin
        drive = {W{en}};
    end

endmodule

// File: rtl/dual_reg_xcvr.sv
// Module: dual_reg_xcvr (top)
// Two-way bus transceiver with a separately clocked register per direction.
// The pads are split into input, output-data and output-drive vectors.
// Assumes: each clock domain applies rst_n at its own edges, and the outer
// wrapper resolves the drive vectors into tri-state pads.
module dual_reg_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         rst_n,
    input  logic         oe_ab,
    input  logic         oe_ba_n,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_drive,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_drive
);

    logic [W-1:0] reg_a;
    logic [W-1:0] reg_b;

    // A-side register, clocked by the A-to-B clock
    xcvr_store #(.W(W)) u_store_a (
        .clk   (clk_ab),
        .rst_n (rst_n),
        .d     (a_in),
        .q     (reg_a)
    );

    // B-side register, clocked by the B-to-A clock
    xcvr_store #(.W(W)) u_store_b (
        .clk   (clk_ba),
        .rst_n (rst_n),
        .d     (b_in),
        .q     (reg_b)
    );

    // A-to-B direction, enable active high
    xcvr_path #(.W(W), .OE_ACTIVE_LOW(1'b0)) u_path_ab (
        .oe     (oe_ab),
        .sel    (src_e'(sel_ab)),
        .live   (a_in),
        .stored (reg_a),
        .dout   (b_out),
        .drive  (b_drive)
    );

    // B-to-A direction, enable active low
    xcvr_path #(.W(W), .OE_ACTIVE_LOW(1'b1)) u_path_ba (
        .oe     (oe_ba_n),
        .sel    (src_e'(sel_ba)),
        .live   (b_in),
        .stored (reg_b),
        .dout   (a_out),
        .drive  (a_drive)
    );

endmodule

// File: rtl/dual_reg_xcvr_chk.sv
// Module: dual_reg_xcvr_chk
// Port-level checker for dual_reg_xcvr, attached by the bind below.
// Assumes: both capture clocks toggle often enough to sample the paths.
module dual_reg_xcvr_chk #(
    parameter int W = 8
) (
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         rst_n,
    input logic         oe_ab,
    input logic         oe_ba_n,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_drive,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_drive
);

    // R1: a stored A value appears on b_out before the next capture
    a_r1_stored_ab: assert property (@(posedge clk_ab) disable iff (!rst_n)
        ($past(rst_n) && sel_ab) |-> (b_out == $past(a_in)));

    // R2: a stored B value appears on a_out before the next capture
    a_r2_stored_ba: assert property (@(posedge clk_ba) disable iff (!rst_n)
        ($past(rst_n) && sel_ba) |-> (a_out == $past(b_in)));

    // R4: the B bus drive follows the active-high enable
    a_r4_b_drive_on: assert property (@(posedge clk_ab) disable iff (!rst_n)
        oe_ab |-> ($countones(b_drive) == W));
    a_r4_b_drive_off: assert property (@(posedge clk_ab) disable iff (!rst_n)
        !oe_ab |-> ($countones(b_drive) == 0));

    // R5: the A bus drive follows the active-low enable
    a_r5_a_drive_on: assert property (@(posedge clk_ba) disable iff (!rst_n)
        !oe_ba_n |-> ($countones(a_drive) == W));
    a_r5_a_drive_off: assert property (@(posedge clk_ba) disable iff (!rst_n)
        oe_ba_n |-> ($countones(a_drive) == 0));

    // R6: the live A-to-B path passes a_in straight through
    a_r6_live_ab: assert property (@(posedge clk_ba) disable iff (!rst_n)
        !sel_ab |-> (b_out == a_in));

    // R7: the live B-to-A path passes b_in straight through
    a_r7_live_ba: assert property (@(posedge clk_ab) disable iff (!rst_n)
        !sel_ba |-> (a_out == b_in));

    // R8: a capture edge under reset leaves a zero register
    a_r8_clear_a: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (!$past(rst_n) && sel_ab) |-> (b_out == '0));

endmodule

bind dual_reg_xcvr dual_reg_xcvr_chk #(.W(W)) u_chk (
    .clk_ab  (clk_ab),
    .clk_ba  (clk_ba),
    .rst_n   (rst_n),
    .oe_ab   (oe_ab),
    .oe_ba_n (oe_ba_n),
    .sel_ab  (sel_ab),
    .sel_ba  (sel_ba),
    .a_in    (a_in),
    .a_out   (a_out),
    .a_drive (a_drive),
    .b_in    (b_in),
    .b_out   (b_out),
    .b_drive (b_drive)
);

// File: tb/tb_dual_reg_xcvr.sv
// Bench for dual_reg_xcvr. It models the outside drivers and bus holders on
// both sides and flags contention. A vector table comes first, then directed
// tests for reset, the self-holding loop and a one-sided reset.
module tb_dual_reg_xcvr;

    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_ab = 1'b0, gate_ba = 1'b0;
    logic oe_ab = 1'b0, oe_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
    logic ext_a_en = 1'b0, ext_b_en = 1'b0;
    logic [W-1:0] ext_a = '0, ext_b = '0;
    logic [W-1:0] a_keep = '0, b_keep = '0;
    logic [W-1:0] a_bus, b_bus, a_out, b_out, a_drive, b_drive;
    logic clk_ab, clk_ba;
    int checks = 0, errors = 0, clashes = 0;

    always #10 clk = ~clk;                 // 50 MHz
    assign clk_ab = clk & gate_ab;         // gates change only while clk is low
    assign clk_ba = clk & gate_ba;

    // Bus resolution: outside driver, else the block, else the bus holder
    assign a_bus = ext_a_en ? ext_a : (|a_drive ? a_out : a_keep);
    assign b_bus = ext_b_en ? ext_b : (|b_drive ? b_out : b_keep);

    always_ff @(posedge clk) begin
        a_keep <= a_bus;
        b_keep <= b_bus;
    end

    dual_reg_xcvr #(.W(W)) dut (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
        .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_bus), .a_out(a_out), .a_drive(a_drive),
        .b_in(b_bus), .b_out(b_out), .b_drive(b_drive)
    );

    // Contention monitor: the block and an outside source on one bus
    always @(negedge clk) begin
        if (ext_a_en && (|a_drive)) clashes++;
        if (ext_b_en && (|b_drive)) clashes++;
    end

    typedef struct packed {
        logic         oeab, oeba_n, sab, sba;
        logic         eaen; logic [7:0] ea;
        logic         eben; logic [7:0] eb;
        logic         pab, pba;
        logic [7:0]   xa, xb;
        logic         xadrv, xbdrv;
    } vec_t;

    localparam int NV = 10;
    localparam logic [41:0] TBL [NV] = '{
        // isolation, capture both (R3)
        {4'b0100, 1'b1, 8'h3C, 1'b1, 8'hA5, 2'b11, 8'h3C, 8'hA5, 2'b00},
        // A to B live (R6, R4)
        {4'b1100, 1'b1, 8'h5A, 1'b0, 8'h00, 2'b00, 8'h5A, 8'h5A, 2'b01},
        // A to B stored, old value (R1)
        {4'b1110, 1'b1, 8'h77, 1'b0, 8'h00, 2'b00, 8'h77, 8'h3C, 2'b01},
        // A to B stored, new capture (R1)
        {4'b1110, 1'b1, 8'hC3, 1'b0, 8'h00, 2'b10, 8'hC3, 8'hC3, 2'b01},
        // B to A live (R7, R5)
        {4'b0000, 1'b0, 8'h00, 1'b1, 8'h96, 2'b00, 8'h96, 8'h96, 2'b10},
        // B to A stored, old value (R2)
        {4'b0001, 1'b0, 8'h00, 1'b1, 8'h11, 2'b00, 8'hA5, 8'h11, 2'b10},
        // B to A stored, new capture (R2)
        {4'b0001, 1'b0, 8'h00, 1'b1, 8'hE7, 2'b01, 8'hE7, 8'hE7, 2'b10},
        // isolation, A capture only (R11)
        {4'b0100, 1'b1, 8'h0F, 1'b1, 8'hF0, 2'b10, 8'h0F, 8'hF0, 2'b00},
        // both stored (R10, R11)
        {4'b1011, 1'b0, 8'h00, 1'b0, 8'h00, 2'b00, 8'hE7, 8'h0F, 2'b11},
        // both stored with both clocks: exchange (R10)
        {4'b1011, 1'b0, 8'h00, 1'b0, 8'h00, 2'b11, 8'h0F, 8'hE7, 2'b11}
    };

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply a vector at a falling edge, let one rising edge pass, then sample
    task automatic apply(input vec_t v);
        @(negedge clk);
        {oe_ab, oe_ba_n, sel_ab, sel_ba} = {v.oeab, v.oeba_n, v.sab, v.sba};
        ext_a_en = v.eaen; ext_a = v.ea;
        ext_b_en = v.eben; ext_b = v.eb;
        gate_ab = v.pab; gate_ba = v.pba;
        @(negedge clk);
        gate_ab = 1'b0; gate_ba = 1'b0;
    endtask

    initial begin : watchdog
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        // Reset both domains with both clocks running (R8)
        gate_ab = 1'b1; gate_ba = 1'b1;
        repeat (3) @(negedge clk);
        gate_ab = 1'b0; gate_ba = 1'b0;
        rst_n = 1'b1;
        oe_ab = 1'b1; oe_ba_n = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
        @(negedge clk);
        chk("R8 reset A register", b_out, 8'h00);
        chk("R8 reset B register", a_out, 8'h00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = vec_t'(TBL[i]);
            apply(v);
            chk($sformatf("R1/R2/R3/R6/R7/R10/R11 vec%0d A bus", i), a_bus, v.xa);
            chk($sformatf("R1/R2/R3/R6/R7/R10/R11 vec%0d B bus", i), b_bus, v.xb);
            chk($sformatf("R5 vec%0d a_drive", i), a_drive, {W{v.xadrv}});
            chk($sformatf("R4 vec%0d b_drive", i), b_drive, {W{v.xbdrv}});
        end
        // Registers now: A holds E7, B holds 0F

        // R9: build the loop, release outside drivers, expect a hold
        apply(vec_t'({4'b1100, 1'b1, 8'h6B, 1'b0, 8'h00, 2'b00, 16'h0, 2'b00}));
        @(negedge clk);
        ext_a_en = 1'b0; oe_ba_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 loop holds A bus", a_bus, 8'h6B);
        chk("R9 loop holds B bus", b_bus, 8'h6B);

        // R8: reset at an A-clock edge only, B register keeps 0F
        @(negedge clk);
        oe_ab = 1'b0; oe_ba_n = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
        ext_a_en = 1'b1; ext_a = 8'hAA; ext_b_en = 1'b1; ext_b = 8'hBB;
        rst_n = 1'b0; gate_ab = 1'b1;
        @(negedge clk);
        gate_ab = 1'b0; rst_n = 1'b1;
        ext_a_en = 1'b0; ext_b_en = 1'b0;
        oe_ab = 1'b1; oe_ba_n = 1'b0;
        @(negedge clk);
        chk("R8 A register cleared", b_out, 8'h00);
        chk("R8 B register untouched (R11)", a_out, 8'h0F);

        // R4/R5: no cycle had contention
        checks++;
        if (clashes != 0) begin
            errors++;
            $display("FAIL R4/R5 contention cycles actual=%0d expected=0", clashes);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule